// File: doc/BRIEF.md
# Shared Ramp Count Sequencer

This block produces the per-line timing for a column driver in which every channel samples one shared analog ramp. One instance serves all channels. A line-start pulse launches a fixed sequence: a reset phase that clears the count and commands the external ramp back to its base level, then a count phase in which a binary code climbs one LSB per step period while a step strobe tells each colour's ramp generator to move up one level in lockstep, and finally a settle phase in which the count is frozen so the channel output amplifiers can settle before the next line.

Each channel compares the broadcast count with the coarse part of its own pixel code and stops sampling the ramp on a match. The count runs one value past the top coarse code, so a channel whose coarse code is at the maximum can still sample the next-higher ramp level for fine interpolation. The step period, reset length and settle length are parameters counted in main-clock cycles. A line start that arrives in any phase abandons the current line and restarts the sequence at once.

Top module: `ramp_line_seq`

## Requirements
- R1: While rst_ni is low, phase_o is 0 (idle), count_o is 0, and ramp_rst_o, ramp_step_o and line_done_o are all low.
- R2: The cycle after line_start_i is sampled high, phase_o is 1 (reset) and count_o is 0; ramp_rst_o is high exactly while phase_o is 1, which lasts RST_CYC cycles.
- R3: After the reset phase, phase_o is 2 (count) and count_o starts at 0, holding each value for STEP_CYC cycles before rising by exactly one.
- R4: count_o is CNT_W+1 bits wide and during one line takes every value from 0 to 2**CNT_W (65 values with CNT_W = 6), never exceeding 2**CNT_W.
- R5: Bit c of ramp_step_o is a one-cycle pulse in the first cycle of each new count value 1 to 2**CNT_W, provided bit c of color_en_i is high; at no other time is it high.
- R6: After the top count value has been held STEP_CYC cycles, phase_o is 3 (settle) for SETTLE_CYC cycles, during which count_o stays at 2**CNT_W and no step strobe fires.
- R7: line_done_o is high for exactly one cycle, the last cycle of the settle phase; the next cycle phase_o returns to 0 and count_o keeps 2**CNT_W.
- R8: A line_start_i pulse in any phase restarts the sequence: the next cycle is the first reset-phase cycle with count_o at 0.
- R9: A low bit of color_en_i suppresses only that colour's step strobe; count_o and the other strobes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | One-cycle pulse starting a horizontal line |
| color_en_i | input | NUM_COLOR | Per-colour ramp step enable |
| count_o | output | CNT_W+1 | Count broadcast to all channels |
| ramp_rst_o | output | 1 | Ramp reset command, high during the reset phase |
| ramp_step_o | output | NUM_COLOR | Per-colour ramp step strobe |
| phase_o | output | 2 | Phase: 0 idle, 1 reset, 2 count, 3 settle |
| line_done_o | output | 1 | One-cycle pulse in the last settle cycle |

## Verification
Every output is registered or decoded from registered state, so the first result of a line start sampled at a rising edge is due one cycle later, and from then on the outputs follow a fixed per-cycle schedule of RST_CYC reset cycles, 65 times STEP_CYC count cycles and SETTLE_CYC settle cycles. The bench's driver raises line_start_i at a falling edge and, at the same moment, fills a queue with one expected output vector per future cycle; a monitor pops one vector one nanosecond after each rising edge and compares every output field against it. A restart flushes the queue, so the schedule re-aligns to the cycle after the new pulse.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RESET  = 2'd1,
    PH_COUNT  = 2'd2,
    PH_SETTLE = 2'd3
  } phase_e;
endpackage

// File: rtl/ramp_phase_fsm.sv
module ramp_phase_fsm
  import ramp_seq_pkg::*;
#(
  parameter int RST_CYC    = 2,
  parameter int STEP_CYC   = 2,
  parameter int SETTLE_CYC = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   line_start_i,
  input  logic   at_top_i,
  output phase_e phase_o,
  output logic   clr_o,
  output logic   adv_o,
  output logic   done_o
);
  localparam int MAX_A   = (RST_CYC > STEP_CYC) ? RST_CYC : STEP_CYC;
  localparam int MAX_CYC = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int TMR_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [TMR_W-1:0] RST_LAST  = TMR_W'(RST_CYC - 1);
  localparam logic [TMR_W-1:0] STEP_LAST = TMR_W'(STEP_CYC - 1);
  localparam logic [TMR_W-1:0] SET_LAST  = TMR_W'(SETTLE_CYC - 1);

  phase_e           state_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      tmr_q   <= '0;
    end else if (line_start_i) begin
      state_q <= PH_RESET;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        PH_RESET:
          if (tmr_q == RST_LAST) begin
            state_q <= PH_COUNT;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        PH_COUNT:
          if (tmr_q == STEP_LAST) begin
            tmr_q <= '0;
            if (at_top_i) state_q <= PH_SETTLE;
          end else tmr_q <= tmr_q + 1'b1;
        PH_SETTLE:
          if (tmr_q == SET_LAST) begin
            state_q <= PH_IDLE;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        default: tmr_q <= '0;
      endcase
    end
  end

  assign phase_o = state_q;
  assign clr_o   = line_start_i;
  assign adv_o   = (state_q == PH_COUNT) && (tmr_q == STEP_LAST) && !at_top_i && !line_start_i;
  assign done_o  = (state_q == PH_SETTLE) && (tmr_q == SET_LAST);

  // R8: restart from any phase
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (state_q == PH_RESET) && (tmr_q == '0));
  // R7: done is followed by idle
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !line_start_i) |=> (state_q == PH_IDLE));
  // R6: settle entered only from count at the top value
  p_settle_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PH_SETTLE) && !line_start_i |=> (state_q != PH_SETTLE) || $past(at_top_i));
endmodule

// File: rtl/ramp_step_counter.sv
module ramp_step_counter #(
  parameter int CNT_W     = 6,
  parameter int NUM_COLOR = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 adv_i,
  input  logic [NUM_COLOR-1:0] color_en_i,
  output logic [CNT_W:0]       count_o,
  output logic [NUM_COLOR-1:0] step_o,
  output logic                 at_top_o
);
  localparam int              OW  = CNT_W + 1;
  localparam logic [OW-1:0]   TOP = OW'(2 ** CNT_W);
  localparam logic [OW-1:0]   ONE = OW'(1);

  logic [OW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + ONE;
  end

  for (genvar c = 0; c < NUM_COLOR; c++) begin : g_step
    logic step_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) step_q <= 1'b0;
      else         step_q <= adv_i && !clr_i && color_en_i[c];
    end
    assign step_o[c] = step_q;

    // R5: a strobe marks a fresh count value
    p_step_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_q |-> (cnt_q == $past(cnt_q) + ONE));
  end

  assign count_o  = cnt_q;
  assign at_top_o = (cnt_q == TOP);

  // R4: count never passes the top value
  p_cnt_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
  // R2: clear lands on zero
  p_clr_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  // R6: without a step the count holds
  p_cnt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ramp_line_seq.sv
module ramp_line_seq
  import ramp_seq_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int NUM_COLOR  = 3,
  parameter int RST_CYC    = 2,
  parameter int STEP_CYC   = 2,
  parameter int SETTLE_CYC = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_start_i,
  input  logic [NUM_COLOR-1:0] color_en_i,
  output logic [CNT_W:0]       count_o,
  output logic                 ramp_rst_o,
  output logic [NUM_COLOR-1:0] ramp_step_o,
  output logic [1:0]           phase_o,
  output logic                 line_done_o
);
  phase_e phase;
  logic   clr, adv, at_top, done;

  ramp_phase_fsm #(
    .RST_CYC   (RST_CYC),
    .STEP_CYC  (STEP_CYC),
    .SETTLE_CYC(SETTLE_CYC)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .at_top_i    (at_top),
    .phase_o     (phase),
    .clr_o       (clr),
    .adv_o       (adv),
    .done_o      (done)
  );

  ramp_step_counter #(
    .CNT_W    (CNT_W),
    .NUM_COLOR(NUM_COLOR)
  ) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .adv_i     (adv),
    .color_en_i(color_en_i),
    .count_o   (count_o),
    .step_o    (ramp_step_o),
    .at_top_o  (at_top)
  );

  assign phase_o     = phase;
  assign ramp_rst_o  = (phase == PH_RESET);
  assign line_done_o = done;

  // R2: ramp reset only with a zero count
  p_rst_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_rst_o |-> (count_o == '0));
  // R6: no strobe outside the count phase
  p_step_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_step_o != '0) |-> (phase == PH_COUNT));
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o);
endmodule

// File: tb/test_ramp_line_seq.sv
module test_ramp_line_seq;
  localparam int CNT_W = 6, NC = 3, RST = 2, STEP = 2, SET = 8;
  localparam int TOP = 2 ** CNT_W;

  typedef struct packed {
    logic [1:0]     ph;
    logic [CNT_W:0] cnt;
    logic           rr;
    logic [NC-1:0]  st;
    logic           dn;
  } exp_t;

  logic clk = 0, rst_ni = 0, line_start = 0;
  logic [NC-1:0] color_en = '0;
  logic [CNT_W:0] count;
  logic rr, dn;
  logic [NC-1:0] st;
  logic [1:0] ph;

  int checks = 0, errors = 0, cyc = 0;
  exp_t exp_q[$];
  string ctx = "";

  always #2 clk = ~clk;

  ramp_line_seq #(.CNT_W(CNT_W), .NUM_COLOR(NC), .RST_CYC(RST),
                  .STEP_CYC(STEP), .SETTLE_CYC(SET)) i_ramp_line_seq (
    .clk_i(clk), .rst_ni(rst_ni), .line_start_i(line_start), .color_en_i(color_en),
    .count_o(count), .ramp_rst_o(rr), .ramp_step_o(st), .phase_o(ph), .line_done_o(dn));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, ctx, act, exp, cyc);
    end
  endtask

  task automatic start_line(input logic [NC-1:0] en);
    @(negedge clk);
    color_en = en;
    line_start = 1;
    exp_q.delete();
    for (int r = 0; r < RST; r++) exp_q.push_back('{2'd1, '0, 1'b1, '0, 1'b0});
    for (int v = 0; v <= TOP; v++)
      for (int k = 0; k < STEP; k++)
        exp_q.push_back('{2'd2, (CNT_W+1)'(v), 1'b0, (k == 0 && v > 0) ? en : '0, 1'b0});
    for (int s = 0; s < SET; s++)
      exp_q.push_back('{2'd3, (CNT_W+1)'(TOP), 1'b0, '0, s == SET - 1});
    for (int i = 0; i < 2; i++) exp_q.push_back('{2'd0, (CNT_W+1)'(TOP), 1'b0, '0, 1'b0});
    @(negedge clk);
    line_start = 0;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        case (e.ph)
          2'd1: check(ph == e.ph, "R2", ph, e.ph);
          2'd2: check(ph == e.ph, "R3", ph, e.ph);
          2'd3: check(ph == e.ph, "R6", ph, e.ph);
          default: check(ph == e.ph, "R7", ph, e.ph);
        endcase
        if (e.cnt == TOP) check(count == e.cnt, "R4", count, e.cnt);
        else              check(count == e.cnt, "R3", count, e.cnt);
        check(rr == e.rr, "R2", rr, e.rr);
        if (color_en != '1) check(st == e.st, "R9", st, e.st);
        else                check(st == e.st, "R5", st, e.st);
        check(dn == e.dn, "R7", dn, e.dn);
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ph == 2'd0, "R1", ph, 0);
    check(count == '0, "R1", count, 0);
    check(rr == 1'b0 && st == '0 && dn == 1'b0, "R1", {rr, st, dn}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    check(ph == 2'd0 && count == '0, "R1", ph, 0);

    ctx = "full line";
    start_line(3'b111);
    while (exp_q.size() > 0) @(negedge clk);

    ctx = "R9 partial enable";
    start_line(3'b101);
    while (exp_q.size() > 0) @(negedge clk);

    ctx = "R8 restart in count";
    start_line(3'b111);
    repeat (20) @(negedge clk);
    start_line(3'b010);
    while (exp_q.size() > 0) @(negedge clk);

    ctx = "R8 restart in settle";
    start_line(3'b011);
    repeat (RST + (TOP + 1) * STEP + 2) @(negedge clk);
    check(ph == 2'd3, "R6", ph, 3);
    start_line(3'b000);
    while (exp_q.size() > 0) @(negedge clk);

    ctx = "R8 restart in reset";
    start_line(3'b100);
    start_line(3'b111);
    while (exp_q.size() > 0) @(negedge clk);

    repeat (4) @(negedge clk);
    check(ph == 2'd0 && dn == 1'b0, "R7", ph, 0);
    check(count == (CNT_W+1)'(TOP), "R7", count, TOP);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule